// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave with Command Decoder

This block is the serial front end and storage of a small nonvolatile-memory model. A host selects it with a chip-select line, clocks it with a serial clock and feeds one data-input line; every sample is taken on a rising serial clock. The serial lines are brought into a faster system clock through synchronizers. The block waits for a 1 start bit and then collects a two-bit opcode, an address and, for the writing commands, a data word. It reads, erases and writes single words, sets or clears a write-enable latch, and clears or fills the whole array. Read data and ready/busy status leave on one data-output pin that has its own output-enable.

A static strap picks between 16-bit and 8-bit word organization over the same 4096-bit byte array. Programming commands change memory on the falling edge of chip select. At the same moment a one-cycle start pulse goes to an external program/erase sequencer. While that sequencer reports busy, the block decodes nothing and shows its status on the data-output pin.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset the data output is disabled, the write-enable latch is clear, the start pulse is low and every memory byte reads 0xFF.
- R2: While chip select is high and no command is in progress, 0 bits on the data input are skipped. The first 1 bit is taken as the start bit.
- R3: With `org16_i` = 1, words are 16 bits and the address is 8 bits, so an instruction is 11 bits long. With `org16_i` = 0, words are 8 bits and the address is 9 bits, so an instruction is 12 bits long. The 16-bit word at address a holds byte 2a in its upper half and byte 2a+1 in its lower half, as seen in 8-bit mode.
- R4: The two opcode bits that follow the start bit select the command: 10 read, 11 erase, 01 write, 00 extended. For the extended opcode, the two most significant address bits select the sub-command: 11 enables writes, 00 disables writes, 10 erases the whole array, 01 writes the whole array. The other address bits are ignored.
- R5: A read enables the output from the serial clock edge that samples the last address bit. It first drives one 0 bit, then the addressed word MSB first. Each new bit appears after a rising serial clock edge.
- R6: If chip select stays high, a read continues with the next word at the following address with no extra 0 bit. After the last address it continues at address 0.
- R7: Erase sets a word to all ones. Write stores the data word whatever the old contents were.
- R8: Erase-all sets every byte to 0xFF. Write-all stores the data word in every location.
- R9: While the write-enable latch is clear, erase, write, erase-all and write-all change nothing and raise no start pulse. Reads are never blocked.
- R10: A complete, enabled programming command changes memory and pulses `seq_start_o` for exactly one cycle when chip select falls. If chip select falls before a command is complete, the command is dropped and memory is left unchanged.
- R11: While `seq_busy_i` is high, no new command is accepted. The sequencer must raise busy in the cycle after the start pulse.
- R12: After a start pulse, while chip select is high, the output is enabled and shows the inverse of busy. Status stays armed until the device is ready and either chip select is low or a 1 is sampled on the data input; that 1 is consumed and disables the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org16_i | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects 8-bit words |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data input |
| do_o | output | 1 | Serial data output (read data or ready status) |
| do_oe_o | output | 1 | Output enable for `do_o` |
| seq_start_o | output | 1 | One-cycle start request to the program/erase sequencer |
| seq_busy_i | input | 1 | Sequencer busy flag |

## Verification
The hardest case to reach is a command that arrives while busy but with status polling not armed. Polling arms on every start pulse and absorbs all input bits while busy, so busy from a real programming cycle hides any separate busy gating. The bench therefore drives the sequencer's busy flag high on its own with no cycle pending, sends a full write and then confirms through a read that the location is unchanged. Address wrap is reached with full sequential sweeps of 257 words in 16-bit mode and 513 bytes in 8-bit mode.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_DONE, ST_READ
    } mw_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_ERASE, OP_WRITE, OP_ERAL, OP_WRAL
    } mw_op_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
    localparam logic [1:0] EXT_WENA  = 2'b11;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mw_store.sv
`timescale 1ns/1ps
module mw_store
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              org16_i,
    input  mw_op_e            op_i,
    input  logic [ADDR_W:0]   addr_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic [ADDR_W:0]   rd_addr_i,
    output logic [WORD_W-1:0] rd_word_o
);
    localparam int AW     = ADDR_W + 1;
    localparam int NBYTES = 1 << AW;

    logic [NBYTES*BYTE_W-1:0] mem_flat;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam logic [AW-1:0] IDX = AW'(i);
        logic             hit;
        logic [BYTE_W-1:0] wval;
        logic [BYTE_W-1:0] byte_d;
        logic [BYTE_W-1:0] byte_q;

        always_comb begin
            hit  = org16_i ? (IDX[AW-1:1] == addr_i[AW-2:0]) : (IDX == addr_i);
            wval = (org16_i && !IDX[0]) ? data_i[WORD_W-1:BYTE_W] : data_i[BYTE_W-1:0];
            byte_d = byte_q;
            unique case (op_i)
                OP_ERASE: if (hit) byte_d = '1;
                OP_WRITE: if (hit) byte_d = wval;
                OP_ERAL:  byte_d = '1;
                OP_WRAL:  byte_d = wval;
                default:  byte_d = byte_q;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byte_q <= '1;
            else        byte_q <= byte_d;
        end

        assign mem_flat[i*BYTE_W +: BYTE_W] = byte_q;
    end

    logic [AW-1:0] hi_idx;
    logic [AW-1:0] lo_idx;

    always_comb begin
        hi_idx = org16_i ? {rd_addr_i[AW-2:0], 1'b0} : rd_addr_i;
        lo_idx = {rd_addr_i[AW-2:0], 1'b1};
        rd_word_o[WORD_W-1:BYTE_W] = mem_flat[hi_idx*BYTE_W +: BYTE_W];
        rd_word_o[BYTE_W-1:0] = org16_i ? mem_flat[lo_idx*BYTE_W +: BYTE_W] : '0;
    end

    // R8: a whole-array clear leaves the first and last byte at all ones
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ERAL) |=> (mem_flat[BYTE_W-1:0] == '1 &&
                               mem_flat[NBYTES*BYTE_W-1 -: BYTE_W] == '1));
endmodule

// File: rtl/mw_eeprom_slave.sv
`timescale 1ns/1ps
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org16_i,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o,
    output logic seq_start_o,
    input  logic seq_busy_i
);
    localparam int AW  = ADDR_W + 1;
    localparam int CW  = $clog2(WORD_W) + 1;
    localparam logic [CW-1:0] LAST_A16 = CW'(ADDR_W - 1);
    localparam logic [CW-1:0] LAST_A8  = CW'(ADDR_W);
    localparam logic [CW-1:0] LAST_W16 = CW'(WORD_W - 1);
    localparam logic [CW-1:0] LAST_W8  = CW'(BYTE_W - 1);

    typedef struct packed {
        mw_state_e         state;
        logic [CW-1:0]     cnt;
        logic [1:0]        opc;
        logic [AW-1:0]     addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] shreg;
        logic              dout;
        logic              rd_oe;
        logic              wen;
        logic              status;
        mw_op_e            pend;
        logic              start;
        logic              cs_prev;
        logic              sk_prev;
    } regs_t;

    localparam regs_t RESET_REGS = '{
        state: ST_IDLE, cnt: '0, opc: '0, addr: '0, data: '0, shreg: '0,
        dout: 1'b0, rd_oe: 1'b0, wen: 1'b0, status: 1'b0, pend: OP_NONE,
        start: 1'b0, cs_prev: 1'b0, sk_prev: 1'b0
    };

    regs_t q, n;

    logic [3:0] sync_vec;
    logic cs_s, sk_s, di_s, org_s;

    mw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sk_i, di_i, org16_i}),
        .sync_o  (sync_vec)
    );
    assign {cs_s, sk_s, di_s, org_s} = sync_vec;

    logic              sk_rise;
    logic              cs_fall;
    logic [AW-1:0]     na;
    logic [AW-1:0]     na_m;
    logic [AW-1:0]     addr_inc;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic [1:0]        ext;
    logic [CW-1:0]     abit_last;
    logic [CW-1:0]     wbit_last;
    mw_op_e            mem_op;

    mw_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .org16_i   (org_s),
        .op_i      (mem_op),
        .addr_i    (q.addr),
        .data_i    (q.data),
        .rd_addr_i (rd_addr),
        .rd_word_o (rd_word)
    );

    always_comb begin
        sk_rise   = sk_s && !q.sk_prev;
        cs_fall   = q.cs_prev && !cs_s;
        na        = {q.addr[AW-2:0], di_s};
        na_m      = org_s ? {1'b0, na[AW-2:0]} : na;
        addr_inc  = org_s ? {1'b0, q.addr[AW-2:0] + 1'b1} : q.addr + 1'b1;
        rd_addr   = (q.state == ST_ADDR) ? na_m : addr_inc;
        ext       = org_s ? na[ADDR_W-1 -: 2] : na[AW-1 -: 2];
        abit_last = org_s ? LAST_A16 : LAST_A8;
        wbit_last = org_s ? LAST_W16 : LAST_W8;
        mem_op    = OP_NONE;

        n         = q;
        n.start   = 1'b0;
        n.cs_prev = cs_s;
        n.sk_prev = sk_s;

        if (!cs_s) begin
            n.state = ST_IDLE;
            n.rd_oe = 1'b0;
            n.pend  = OP_NONE;
            if (cs_fall && q.state == ST_DONE && q.pend != OP_NONE) begin
                mem_op   = q.pend;
                n.start  = 1'b1;
                n.status = 1'b1;
            end else if (!seq_busy_i && !q.start) begin
                n.status = 1'b0;
            end
        end else if (sk_rise) begin
            if (q.status) begin
                if (!seq_busy_i && di_s) n.status = 1'b0;
            end else begin
                unique case (q.state)
                    ST_IDLE: begin
                        if (di_s && !seq_busy_i) begin
                            n.state = ST_OPC;
                            n.cnt   = '0;
                        end
                    end
                    ST_OPC: begin
                        n.opc = {q.opc[0], di_s};
                        n.cnt = q.cnt + 1'b1;
                        if (q.cnt == CW'(1)) begin
                            n.state = ST_ADDR;
                            n.cnt   = '0;
                        end
                    end
                    ST_ADDR: begin
                        n.addr = na;
                        n.cnt  = q.cnt + 1'b1;
                        if (q.cnt == abit_last) begin
                            n.addr  = na_m;
                            n.cnt   = '0;
                            n.state = ST_DONE;
                            unique case (q.opc)
                                OPC_READ: begin
                                    n.state = ST_READ;
                                    n.shreg = rd_word;
                                    n.dout  = 1'b0;
                                    n.rd_oe = 1'b1;
                                end
                                OPC_ERASE: n.pend  = q.wen ? OP_ERASE : OP_NONE;
                                OPC_WRITE: n.state = ST_DATA;
                                default: begin
                                    unique case (ext)
                                        EXT_WENA:  n.wen   = 1'b1;
                                        EXT_WDIS:  n.wen   = 1'b0;
                                        EXT_CLEAR: n.pend  = q.wen ? OP_ERAL : OP_NONE;
                                        default:   n.state = ST_DATA;
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        n.data = {q.data[WORD_W-2:0], di_s};
                        n.cnt  = q.cnt + 1'b1;
                        if (q.cnt == wbit_last) begin
                            n.state = ST_DONE;
                            n.cnt   = '0;
                            if (q.wen) n.pend = (q.opc == OPC_WRITE) ? OP_WRITE : OP_WRAL;
                            else       n.pend = OP_NONE;
                        end
                    end
                    ST_READ: begin
                        n.dout = q.shreg[WORD_W-1];
                        if (q.cnt == wbit_last) begin
                            n.addr  = addr_inc;
                            n.shreg = rd_word;
                            n.cnt   = '0;
                        end else begin
                            n.shreg = {q.shreg[WORD_W-2:0], 1'b0};
                            n.cnt   = q.cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_REGS;
        else        q <= n;
    end

    assign seq_start_o = q.start;
    assign do_oe_o     = cs_s && (q.status || q.rd_oe);
    assign do_o        = (q.status && cs_s) ? !seq_busy_i : q.dout;

    // R10: the sequencer start request lasts one cycle only
    assert_start_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |=> !q.start);

    // R9: no program cycle may be requested without the enable latch set
    assert_start_needs_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.start |-> q.wen);

    // R11: a busy sequencer keeps the decoder waiting for a start bit
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy_i && q.state == ST_IDLE) |=> (q.state == ST_IDLE));

    // R5: the first bit driven by a read is a 0
    assert_lead_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rd_oe) |-> !q.dout);

    // R10: deselect drops any partial command
    assert_abort_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cs_prev && !cs_s) |=> (q.state == ST_IDLE && q.pend == OP_NONE));
endmodule

// File: tb/mw_eeprom_slave_test.sv
`timescale 1ns/1ps
module mw_eeprom_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org = 1'b1;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic busy_force = 1'b0;
    logic do_o, do_oe_o, seq_start_o, seq_busy;
    logic [7:0] bcnt = '0;
    int checks = 0;
    int fails = 0;
    int starts = 0;
    logic wen_m = 1'b0;
    logic [7:0] model [512];

    always #2.5 clk = ~clk;

    mw_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .org16_i(org), .cs_i(cs), .sk_i(sk), .di_i(di),
        .do_o(do_o), .do_oe_o(do_oe_o), .seq_start_o(seq_start_o), .seq_busy_i(seq_busy)
    );

    always @(posedge clk) begin
        if (seq_start_o) begin
            bcnt   <= 8'd60;
            starts <= starts + 1;
        end else if (bcnt != 0) begin
            bcnt <= bcnt - 1'b1;
        end
    end
    assign seq_busy = (bcnt != 0) || busy_force;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int aw(); return org ? 8 : 9; endfunction
    function automatic int ww(); return org ? 16 : 8; endfunction
    function automatic int nloc(); return org ? 256 : 512; endfunction
    function automatic logic [8:0] ext_addr(input logic [1:0] e);
        return org ? {1'b0, e, 6'b0} : {e, 7'b0};
    endfunction
    function automatic logic [15:0] exp_word(input int a);
        return org ? {model[2*a], model[2*a+1]} : {8'h00, model[a]};
    endfunction

    task automatic tick(input logic b, output logic o);
        di = b;
        repeat (4) @(negedge clk);
        o = do_o;
        sk = 1'b1;
        repeat (4) @(negedge clk);
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int nb);
        logic o;
        for (int i = nb - 1; i >= 0; i--) tick(v[i], o);
    endtask

    task automatic sel();
        cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic desel();
        di = 1'b0;
        cs = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_ready();
        repeat (3) @(negedge clk);
        while (seq_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] opc, input logic [8:0] a);
        send({29'd0, 1'b1, opc}, 3);
        send({23'd0, a}, aw());
    endtask

    task automatic prog(input logic [1:0] opc, input logic [8:0] a, input bit has_data,
                        input logic [15:0] d);
        sel();
        cmd(opc, a);
        if (has_data) send({16'd0, d}, ww());
        desel();
        wait_ready();
    endtask

    task automatic m_put(input int a, input logic [15:0] d);
        if (org) begin model[2*a] = d[15:8]; model[2*a+1] = d[7:0]; end
        else model[a] = d[7:0];
    endtask

    task automatic do_write(input int a, input logic [15:0] d);
        prog(2'b01, 9'(a), 1'b1, d);
        if (wen_m) m_put(a, d);
    endtask

    task automatic do_erase(input int a);
        prog(2'b11, 9'(a), 1'b0, 16'h0);
        if (wen_m) m_put(a, 16'hFFFF);
    endtask

    task automatic do_fill(input logic [15:0] d);
        prog(2'b00, ext_addr(2'b01), 1'b1, d);
        if (wen_m) for (int a = 0; a < nloc(); a++) m_put(a, d);
    endtask

    task automatic do_clear();
        prog(2'b00, ext_addr(2'b10), 1'b0, 16'h0);
        if (wen_m) for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    endtask

    task automatic do_wen(input logic en);
        sel();
        cmd(2'b00, ext_addr(en ? 2'b11 : 2'b00));
        desel();
        wen_m = en;
    endtask

    task automatic read_check(input int a, input int nw, input int lead, input string req);
        logic o;
        logic [15:0] got;
        int cur;
        sel();
        for (int z = 0; z < lead; z++) tick(1'b0, o);
        cmd(2'b10, 9'(a));
        tick(1'b0, o);
        chk(o == 1'b0 && do_oe_o == 1'b1, {req, " lead zero"}, {o, do_oe_o}, 2'b01);
        cur = a;
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int b = 0; b < ww(); b++) begin
                tick(1'b0, o);
                got = {got[14:0], o};
            end
            chk(got == exp_word(cur), req, got, exp_word(cur));
            cur = (cur + 1) % nloc();
        end
        desel();
        chk(do_oe_o == 1'b0, {req, " release"}, do_oe_o, 0);
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        repeat (170000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        logic o;
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        chk(do_oe_o == 1'b0 && seq_start_o == 1'b0, "R1 reset outputs", {do_oe_o, seq_start_o}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        read_check(0, 1, 0, "R1");

        // R9: writes before enabling are dropped
        s0 = starts;
        do_write(5, 16'h1234);
        chk(starts == s0, "R9 no start", starts, s0);
        read_check(5, 1, 0, "R9");

        // R4: enable, then R12 status polling on a real cycle
        do_wen(1'b1);
        sel();
        cmd(2'b01, 9'd0);
        send(32'h0000BEEF, 16);
        desel();
        m_put(0, 16'hBEEF);
        chk(starts == s0 + 1, "R10 start pulse", starts, s0 + 1);
        sel();
        chk(do_oe_o == 1'b1 && do_o == 1'b0, "R12 busy shown", {do_oe_o, do_o}, 2'b10);
        while (seq_busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(do_oe_o == 1'b1 && do_o == 1'b1, "R12 ready shown", {do_oe_o, do_o}, 2'b11);
        tick(1'b1, o);
        repeat (2) @(negedge clk);
        chk(do_oe_o == 1'b0, "R12 released", do_oe_o, 0);
        desel();
        wait_ready();
        read_check(0, 1, 0, "R4 R7");

        for (int k = 0; k < 8; k++) begin
            int a;
            a = (k * 37 + 1) % 256;
            do_write(a, 16'(a * 16'h0101 ^ 16'h5A3C));
        end
        do_write(255, 16'h0102);
        do_write(254, 16'h7E81);

        read_check(254, 1, 3, "R2");
        read_check(0, 257, 0, "R6");

        do_erase(38);
        read_check(37, 3, 0, "R7 erase");
        do_write(1, 16'hC0DE);
        read_check(1, 1, 0, "R7 overwrite");

        // R10: abort in the address and in the data field
        s0 = starts;
        sel();
        send(32'h5, 3);
        send(32'h3, 4);
        desel();
        sel();
        cmd(2'b01, 9'd1);
        send(32'h2AA, 10);
        desel();
        wait_ready();
        chk(starts == s0, "R10 abort no start", starts, s0);
        read_check(1, 1, 0, "R10");

        // R11: busy raised with no pending cycle
        busy_force = 1'b1;
        sel();
        cmd(2'b01, 9'd3);
        send(32'h0000DEAD, 16);
        desel();
        busy_force = 1'b0;
        wait_ready();
        chk(starts == s0, "R11 no start", starts, s0);
        read_check(3, 1, 0, "R11");

        do_fill(16'hC33C);
        read_check(250, 8, 0, "R8 fill");
        do_clear();
        read_check(255, 3, 0, "R8 clear");
        do_write(10, 16'hA1B2);
        do_write(255, 16'h0102);

        // R3: byte view of the same array
        org = 1'b0;
        repeat (8) @(negedge clk);
        read_check(0, 513, 0, "R3");
        do_write(300, 16'h005A);
        do_erase(21);
        read_check(299, 3, 0, "R3 x8 write");
        read_check(20, 2, 0, "R7 x8 erase");
        do_fill(16'h003C);
        read_check(509, 5, 0, "R8 x8 fill");
        do_clear();
        read_check(100, 2, 0, "R8 x8 clear");
        do_wen(1'b0);
        s0 = starts;
        do_write(7, 16'h0011);
        do_fill(16'h0022);
        chk(starts == s0, "R9 disabled", starts, s0);
        read_check(6, 3, 0, "R9 R4 disabled");

        org = 1'b1;
        repeat (8) @(negedge clk);
        read_check(0, 1, 0, "R3 back");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule